// File: doc/BRIEF.md
# Multi-Segment Duty Fade Sequencer

This block moves a PWM channel's duty value along a chain of up to sixteen linear segments. Together the segments approximate a brightness curve such as a gamma curve. Each segment is one 32-bit word in a small local parameter RAM. The word holds a direction, a number of PWM periods between steps, a step size and a step count. Software fills the RAM through a simple write/read port, sets how many segments one fade uses, loads a starting duty and pulses `start`.

After that, the PWM timer's once-per-period `tick` pulse drives the fade. The sequencer applies the steps of the current segment, moves to the next entry, and stops after the last one. When it stops, it raises a sticky end-of-fade status, which can drive an interrupt line. A fade can be frozen with a `pause` strobe and continued with a `resume` strobe. The duty value is clamped at zero and at full scale; it never wraps. Generating the PWM waveform from the duty value is left to a neighbouring block.

Top module: `fade_sequencer`

## Requirements
- R1: A RAM entry is decoded from the least significant bit up:
  - bit 0 is the direction (1 = increase);
  - bits 10:1 are the periods per step;
  - bits 20:11 are the step size;
  - bits 30:21 are the step count;
  - bit 31 is reserved.
  
  Reading an address returns exactly the 32-bit word last written there.
- R2: The edge that samples `start` high loads `duty_init` into `duty` and begins the fade at entry 0.
  - `seg_num` values from 1 to 16 select that many entries.
  - A `seg_num` of 0 ends the fade at once, leaving `duty` at `duty_init`.
- R3: Within a segment, `duty` moves by the step size once every max(periods per step, 1) `tick` pulses, step-count times. `duty` changes only on an edge where `tick` or `start` is high.
- R4: A segment whose step count is 0 is skipped without consuming any `tick`.
- R5: `duty` saturates at 0 when decreasing and at 2^DUTY_W-1 when increasing; it never wraps.
- R6: Entries at or beyond `seg_num` are never used. Once the fade has ended, further ticks leave `duty` unchanged.
- R7: `pause` during a fade freezes it: ticks are ignored. After `resume`, the fade continues from where it stopped.
- R8: `fin_st` goes to 1 when the last segment completes and stays there until a `fin_clr` pulse. A new completion in the same cycle as `fin_clr` takes precedence.
- R9: `fin_irq` is high exactly when both `fin_st` and `fin_ie` are high.
- R10: After reset, `duty`, `fin_st` and `fin_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ram_we | input | 1 | Write strobe for the segment RAM |
| ram_addr | input | 4 | Segment RAM address (write and read) |
| ram_wdata | input | 32 | Segment word to write |
| ram_rdata | output | 32 | Word stored at `ram_addr` |
| seg_num | input | 5 | Number of segments in one fade |
| duty_init | input | 12 | Starting duty, loaded on `start` |
| start | input | 1 | One-cycle pulse that launches a fade |
| pause | input | 1 | One-cycle pulse that freezes a running fade |
| resume | input | 1 | One-cycle pulse that continues a paused fade |
| tick | input | 1 | One-cycle pulse per PWM period |
| duty | output | 12 | Current duty value |
| fin_st | output | 1 | Sticky end-of-fade status |
| fin_ie | input | 1 | Interrupt enable for the end-of-fade status |
| fin_clr | input | 1 | Pulse that clears `fin_st` |
| fin_irq | output | 1 | End-of-fade interrupt |

## Verification
The properties assume the following about the inputs:
- `start`, `pause`, `resume`, `tick` and `fin_clr` are synchronous single-cycle pulses.
- The step size field never exceeds the duty width, so one edge can move `duty` by at most 1023.
- The read-back property assumes the address is held after a write when the word is compared.

The stimulus stays within these assumptions:
- Every strobe is raised for exactly one cycle at the falling edge.
- Ticks are spaced at least three cycles apart, so that skipped segments and the end of a fade settle between them.
- The RAM is written only while no fade is running.

// File: rtl/fade_sequencer.sv
module fade_sequencer #(
  parameter int DUTY_W = 12,
  parameter int SEGS   = 16,
  parameter int FW     = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ram_we,
  input  logic [$clog2(SEGS)-1:0] ram_addr,
  input  logic [3*FW+1:0]      ram_wdata,
  output logic [3*FW+1:0]      ram_rdata,
  input  logic [$clog2(SEGS+1)-1:0] seg_num,
  input  logic [DUTY_W-1:0]    duty_init,
  input  logic                 start,
  input  logic                 pause,
  input  logic                 resume,
  input  logic                 tick,
  output logic [DUTY_W-1:0]    duty,
  output logic                 fin_st,
  input  logic                 fin_ie,
  input  logic                 fin_clr,
  output logic                 fin_irq
);
  localparam int AW = $clog2(SEGS);
  localparam int CW = $clog2(SEGS+1);
  localparam int EW = 3*FW+2;

  logic [EW-1:0] mem [SEGS];
  logic [CW-1:0] seg_idx, total;
  logic [FW-1:0] cyc_cnt, stp_cnt;
  logic          running, paused;

  always_ff @(posedge clk)
    if (ram_we) mem[ram_addr] <= ram_wdata;
  assign ram_rdata = mem[ram_addr];

  logic [EW-1:0] cur;
  logic          e_dir;
  logic [FW-1:0] e_cyc, e_scl, e_cnt, cyc_lim;
  assign cur   = mem[seg_idx[AW-1:0]];
  assign e_dir = cur[0];
  assign e_cyc = cur[FW:1];
  assign e_scl = cur[2*FW:FW+1];
  assign e_cnt = cur[3*FW:2*FW+1];
  assign cyc_lim = (e_cyc == '0) ? FW'(1) : e_cyc;
  assign total = (seg_num > CW'(SEGS)) ? CW'(SEGS) : seg_num;

  logic [DUTY_W:0]   sum, ext;
  logic [DUTY_W-1:0] nxt;
  assign ext = {{(DUTY_W+1-FW){1'b0}}, e_scl};
  assign sum = {1'b0, duty} + ext;
  always_comb begin
    if (e_dir) nxt = sum[DUTY_W] ? '1 : sum[DUTY_W-1:0];
    else       nxt = ({1'b0, duty} < ext) ? '0 : duty - ext[DUTY_W-1:0];
  end

  logic act, ending, step_due, last_step;
  assign act       = running && !paused && !pause && !start;
  assign ending    = act && (seg_idx >= total);
  assign step_due  = ({1'b0, cyc_cnt} + 1'b1) >= {1'b0, cyc_lim};
  assign last_step = ({1'b0, stp_cnt} + 1'b1) == {1'b0, e_cnt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty    <= '0;
      seg_idx <= '0;
      cyc_cnt <= '0;
      stp_cnt <= '0;
      running <= 1'b0;
      paused  <= 1'b0;
    end else if (start) begin
      duty    <= duty_init;
      seg_idx <= '0;
      cyc_cnt <= '0;
      stp_cnt <= '0;
      running <= 1'b1;
      paused  <= 1'b0;
    end else if (running) begin
      if (pause)       paused <= 1'b1;
      else if (resume) paused <= 1'b0;
      if (act) begin
        if (ending) begin
          running <= 1'b0;
        end else if (e_cnt == '0) begin
          seg_idx <= seg_idx + 1'b1;
          cyc_cnt <= '0;
          stp_cnt <= '0;
        end else if (tick) begin
          if (step_due) begin
            duty    <= nxt;
            cyc_cnt <= '0;
            if (last_step) begin
              seg_idx <= seg_idx + 1'b1;
              stp_cnt <= '0;
            end else begin
              stp_cnt <= stp_cnt + 1'b1;
            end
          end else begin
            cyc_cnt <= cyc_cnt + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fin_st <= 1'b0;
    else if (ending)  fin_st <= 1'b1;
    else if (fin_clr) fin_st <= 1'b0;
  end

  assign fin_irq = fin_st & fin_ie;
endmodule

module fade_sequencer_chk #(
  parameter int DUTY_W = 12,
  parameter int SEGS   = 16,
  parameter int FW     = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ram_we,
  input logic [$clog2(SEGS)-1:0] ram_addr,
  input logic [3*FW+1:0]         ram_wdata,
  input logic [3*FW+1:0]         ram_rdata,
  input logic                    start,
  input logic                    resume,
  input logic                    tick,
  input logic [DUTY_W-1:0]       duty,
  input logic                    fin_st,
  input logic                    fin_ie,
  input logic                    fin_clr,
  input logic                    fin_irq,
  input logic                    running,
  input logic                    paused
);
  localparam int MAXSTEP = (1 << FW) - 1;

  // R1
  ram_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (ram_addr != $past(ram_addr)) || (ram_rdata == $past(ram_wdata)));

  // R3
  duty_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(duty));

  // R5
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (((duty >= $past(duty)) ? (duty - $past(duty)) : ($past(duty) - duty)) <= DUTY_W'(MAXSTEP)));

  // R7
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !resume && !start) |=> $stable(duty));

  // R8
  fin_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin_st) |-> $past(running));

  // R8
  fin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_clr && !running) |=> !fin_st);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_irq |-> (fin_ie && fin_st));
endmodule

bind fade_sequencer fade_sequencer_chk #(.DUTY_W(DUTY_W), .SEGS(SEGS), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_addr(ram_addr),
  .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .start(start), .resume(resume),
  .tick(tick), .duty(duty), .fin_st(fin_st), .fin_ie(fin_ie), .fin_clr(fin_clr),
  .fin_irq(fin_irq), .running(running), .paused(paused)
);

// File: tb/test_fade_sequencer.sv
`timescale 1ns/1ps
module test_fade_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ram_we = 1'b0;
  logic [3:0]  ram_addr = '0;
  logic [31:0] ram_wdata = '0;
  logic [31:0] ram_rdata;
  logic [4:0]  seg_num = 5'd1;
  logic [11:0] duty_init = '0;
  logic        start = 1'b0, pause = 1'b0, resume = 1'b0, tick = 1'b0;
  logic [11:0] duty;
  logic        fin_st, fin_ie = 1'b0, fin_clr = 1'b0, fin_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fade_sequencer i_fade_sequencer (
    .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .seg_num(seg_num),
    .duty_init(duty_init), .start(start), .pause(pause), .resume(resume),
    .tick(tick), .duty(duty), .fin_st(fin_st), .fin_ie(fin_ie),
    .fin_clr(fin_clr), .fin_irq(fin_irq)
  );

  // dir, periods per step, step size, step count, initial duty, final duty, ticks to finish
  localparam int VEC [6][7] = '{
    '{1, 1,   10, 5, 100,  150,  5},
    '{0, 2,    3, 4,  50,   38,  8},
    '{1, 3,  100, 2,   0,  200,  6},
    '{1, 1, 1000, 5, 1000, 4095, 5},
    '{0, 1,    7, 3,  10,    0,  3},
    '{1, 0,    1, 4,   0,    4,  4}
  };

  function automatic logic [31:0] mk(int dir, int cyc, int scl, int cnt);
    return {1'b0, cnt[9:0], scl[9:0], cyc[9:0], dir[0]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] w);
    @(negedge clk); ram_addr = a[3:0]; ram_wdata = w; ram_we = 1'b1;
    @(negedge clk); ram_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); fin_clr = 1'b1;
    @(negedge clk); fin_clr = 1'b0;
  endtask

  task automatic one_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ticks_until_end(output int n);
    n = 0;
    while (!fin_st && n < 4000) begin
      one_tick();
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(duty == 0, "R10 duty", duty, 0);
    chk(fin_st == 0, "R10 fin_st", fin_st, 0);
    chk(fin_irq == 0, "R10 fin_irq", fin_irq, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 read back of stored words
    wr(15, 32'hFFFF_FFFF);
    chk(ram_rdata == 32'hFFFF_FFFF, "R1 readback all ones", ram_rdata, 32'hFFFF_FFFF);
    wr(7, mk(1, 513, 2, 1023));
    chk(ram_rdata == 32'h7FE0_1403, "R1 readback fields", ram_rdata, 32'h7FE0_1403);

    // Vector table: single-segment fades
    for (int i = 0; i < 6; i++) begin
      wr(0, mk(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]));
      seg_num = 5'd1;
      duty_init = VEC[i][4][11:0];
      pulse_clr();
      pulse_start();
      chk(duty == VEC[i][4][11:0], "R2 duty_init loaded", duty, VEC[i][4]);
      ticks_until_end(n);
      if (i == 3 || i == 4)
        chk(duty == VEC[i][5][11:0], "R5 saturated final duty", duty, VEC[i][5]);
      else
        chk(duty == VEC[i][5][11:0], "R3 final duty", duty, VEC[i][5]);
      chk(n == VEC[i][6], "R3 ticks to finish", n, VEC[i][6]);
    end

    // R9 interrupt gating and R8 clear
    chk(fin_st == 1, "R8 status set", fin_st, 1);
    chk(fin_irq == 0, "R9 irq masked", fin_irq, 0);
    @(negedge clk); fin_ie = 1'b1;
    @(negedge clk);
    chk(fin_irq == 1, "R9 irq enabled", fin_irq, 1);
    pulse_clr();
    chk(fin_st == 0, "R8 status cleared", fin_st, 0);
    chk(fin_irq == 0, "R9 irq after clear", fin_irq, 0);

    // R4 and R6: multi-segment chain with a skipped entry and an unused one
    wr(0, mk(1, 1, 5, 2));
    wr(1, mk(1, 1, 50, 0));
    wr(2, mk(0, 1, 3, 1));
    wr(3, mk(1, 1, 100, 1));
    seg_num = 5'd3;
    duty_init = 12'd20;
    pulse_start();
    ticks_until_end(n);
    chk(duty == 27, "R4 chain final duty", duty, 27);
    chk(n == 3, "R4 skipped segment takes no tick", n, 3);
    one_tick();
    one_tick();
    chk(duty == 27, "R6 ticks after end ignored", duty, 27);
    pulse_clr();

    // R2 zero segments
    seg_num = 5'd0;
    duty_init = 12'd77;
    pulse_start();
    repeat (3) @(negedge clk);
    chk(fin_st == 1, "R2 zero segments ends at once", fin_st, 1);
    chk(duty == 77, "R2 zero segments keeps duty", duty, 77);
    pulse_clr();

    // R7 pause / resume, R3 no tick no change
    wr(0, mk(1, 1, 1, 10));
    seg_num = 5'd1;
    duty_init = 12'd0;
    pulse_start();
    repeat (10) @(negedge clk);
    chk(duty == 0, "R3 idle without tick", duty, 0);
    for (int k = 0; k < 3; k++) one_tick();
    chk(duty == 3, "R7 before pause", duty, 3);
    @(negedge clk); pause = 1'b1;
    @(negedge clk); pause = 1'b0;
    for (int k = 0; k < 5; k++) one_tick();
    chk(duty == 3, "R7 frozen while paused", duty, 3);
    chk(fin_st == 0, "R7 no end while paused", fin_st, 0);
    @(negedge clk); resume = 1'b1;
    @(negedge clk); resume = 1'b0;
    for (int k = 0; k < 6; k++) one_tick();
    chk(duty == 9 && fin_st == 0, "R7 resumed progress", duty, 9);
    one_tick();
    chk(duty == 10, "R7 resumed final duty", duty, 10);
    chk(fin_st == 1, "R8 status after resumed fade", fin_st, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule